// File: doc/BRIEF.md
# Four-Function Arithmetic/Logic Unit with Condition Flags

This block is the arithmetic core of a small teaching processor. It takes two operand words and a two-bit function code. It returns one of four results: the sum, the difference, the bitwise AND or the bitwise XOR. Alongside the result it returns three condition bits: signed overflow, zero and carry/borrow. The block has no storage. Every output is a function of the present inputs only. Capturing the flags into a condition register is the job of the surrounding pipeline.

Operand B is taken to be the destination value that accumulates. For that reason subtraction yields B minus A. The carry bit holds the carry out of the top bit for addition and the borrow for subtraction. The two logic functions clear both carry and overflow. A parameter chooses the adder variant: an operator-inferred adder or an explicit bit-level ripple chain. The other parameter sets the word width.

Top module: `alu4_core`

## Requirements
- R1: Function code 0 (binary 00) drives `result` with (A + B) modulo 2^WIDTH.
- R2: Function code 1 (binary 01) drives `result` with (B - A) modulo 2^WIDTH.
- R3: Function code 2 (binary 10) drives `result` with A AND B, bit by bit.
- R4: Function code 3 (binary 11) drives `result` with A XOR B, bit by bit.
- R5: `flag_zero` is 1 exactly when every bit of `result` is 0, for all four function codes.
- R6: For code 0, `flag_carry` is the carry out of the most significant bit of A + B. For code 1, `flag_carry` is 1 exactly when B < A as unsigned numbers, which is the borrow.
- R7: For code 0, `flag_ovf` is 1 exactly when A and B have equal sign bits and the sign bit of `result` differs from them.
- R8: For code 1, `flag_ovf` is 1 exactly when A and B have different sign bits and the sign bit of `result` differs from the sign bit of B.
- R9: For codes 2 and 3, `flag_carry` and `flag_ovf` are both 0, whatever the operands.
- R10: All outputs follow a change of any input with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH (32) | Operand A; the subtrahend for code 1 |
| opnd_b | input | WIDTH (32) | Operand B; the minuend for code 1 |
| func_sel | input | 2 | Function code: 0 add, 1 subtract, 2 AND, 3 XOR |
| result | output | WIDTH (32) | Selected function result |
| flag_ovf | output | 1 | Signed overflow |
| flag_zero | output | 1 | Result is all zeros |
| flag_carry | output | 1 | Carry out (add) or borrow (subtract) |

## Verification
Every result and every flag is due within the same cycle as its stimulus, zero clock edges later, because no register lies between the inputs and the outputs. The bench changes the operands and the function code just after a falling clock edge. It reads the outputs one nanosecond later, well before the next rising edge. That a clock edge plays no part is shown by changing the inputs a second time within the same clock phase and checking the new values at once.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

   typedef enum logic [1:0] {
      FN_ADD = 2'd0,
      FN_SUB = 2'd1,
      FN_AND = 2'd2,
      FN_XOR = 2'd3
   } alu_fn_e;

   localparam int unsigned FN_BITS = 2;

endpackage

// File: rtl/alu4_addsub.sv
// Adds or subtracts (B - A). The carry output is already converted to a
// borrow when subtracting. The variant is picked by RIPPLE.
module alu4_addsub #(
   parameter int unsigned WIDTH  = 32,
   parameter bit          RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             do_sub,
   output logic [WIDTH-1:0] sum_out,
   output logic             carry_out,
   output logic             ovf_out
);
   localparam int unsigned MSB = WIDTH - 1;

   logic [WIDTH-1:0] a_eff;
   logic             raw_cout;

   // Subtracting is done as B + ~A + 1.
   assign a_eff = do_sub ? ~a_in : a_in;

   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] chain;
         assign chain[0] = do_sub;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum_out[i]  = a_eff[i] ^ b_in[i] ^ chain[i];
            assign chain[i+1]  = (a_eff[i] & b_in[i]) |
                                 (chain[i] & (a_eff[i] ^ b_in[i]));
         end
         assign raw_cout = chain[WIDTH];
      end else begin : g_infer
         logic [WIDTH:0] wide_sum;
         assign wide_sum = {1'b0, b_in} + {1'b0, a_eff} + {{WIDTH{1'b0}}, do_sub};
         assign sum_out  = wide_sum[WIDTH-1:0];
         assign raw_cout = wide_sum[WIDTH];
      end
   endgenerate

   // A carry out of B + ~A + 1 means there was no borrow.
   assign carry_out = do_sub ? ~raw_cout : raw_cout;
   // Overflow: the two addends share a sign and the sum leaves that sign.
   assign ovf_out   = (b_in[MSB] == a_eff[MSB]) && (sum_out[MSB] != b_in[MSB]);

endmodule

// File: rtl/alu4_bitwise.sv
module alu4_bitwise #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             pick_xor,
   output logic [WIDTH-1:0] logic_out
);
   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign logic_out[i] = pick_xor ? (a_in[i] ^ b_in[i]) : (a_in[i] & b_in[i]);
      end
   endgenerate
endmodule

// File: rtl/alu4_flags.sv
module alu4_flags #(
   parameter int unsigned WIDTH = 32
) (
   input  alu4_pkg::alu_fn_e fn,
   input  logic [WIDTH-1:0]  res_in,
   input  logic              arith_carry,
   input  logic              arith_ovf,
   output logic              zero_out,
   output logic              carry_out,
   output logic              ovf_out
);
   import alu4_pkg::*;

   logic is_arith;

   assign is_arith  = (fn == FN_ADD) || (fn == FN_SUB);
   assign zero_out  = ~|res_in;
   assign carry_out = is_arith & arith_carry;
   assign ovf_out   = is_arith & arith_ovf;
endmodule

// File: rtl/alu4_core.sv
module alu4_core #(
   parameter int unsigned WIDTH         = 32,
   parameter bit          RIPPLE_ADDER  = 1'b0
) (
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic [1:0]       func_sel,
   output logic [WIDTH-1:0] result,
   output logic             flag_ovf,
   output logic             flag_zero,
   output logic             flag_carry
);
   import alu4_pkg::*;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu4_core: WIDTH must be at least 2");
      end
   endgenerate

   alu_fn_e          fn;
   logic [WIDTH-1:0] arith_res;
   logic [WIDTH-1:0] logic_res;
   logic             arith_c;
   logic             arith_v;

   assign fn = alu_fn_e'(func_sel);

   alu4_addsub #(.WIDTH(WIDTH), .RIPPLE(RIPPLE_ADDER)) u_addsub (
      .a_in      (opnd_a),
      .b_in      (opnd_b),
      .do_sub    (fn == FN_SUB),
      .sum_out   (arith_res),
      .carry_out (arith_c),
      .ovf_out   (arith_v)
   );

   alu4_bitwise #(.WIDTH(WIDTH)) u_bitwise (
      .a_in      (opnd_a),
      .b_in      (opnd_b),
      .pick_xor  (fn == FN_XOR),
      .logic_out (logic_res)
   );

   // The function code's upper bit splits arithmetic from logic.
   assign result = func_sel[1] ? logic_res : arith_res;

   alu4_flags #(.WIDTH(WIDTH)) u_flags (
      .fn          (fn),
      .res_in      (result),
      .arith_carry (arith_c),
      .arith_ovf   (arith_v),
      .zero_out    (flag_zero),
      .carry_out   (flag_carry),
      .ovf_out     (flag_ovf)
   );

endmodule

// File: rtl/alu4_core_chk.sv
module alu4_core_chk #(
   parameter int unsigned WIDTH = 32
) (
   input logic [WIDTH-1:0] opnd_a,
   input logic [WIDTH-1:0] opnd_b,
   input logic [1:0]       func_sel,
   input logic [WIDTH-1:0] result,
   input logic             flag_ovf,
   input logic             flag_zero,
   input logic             flag_carry
);
   localparam int unsigned MSB = WIDTH - 1;

   logic [WIDTH:0] ref_add;

   assign ref_add = {1'b0, opnd_a} + {1'b0, opnd_b};

   always_comb begin
      if (!$isunknown({opnd_a, opnd_b, func_sel})) begin
         a_r1_add_sum: assert (func_sel != 2'd0 || result == ref_add[WIDTH-1:0]);
         a_r2_sub_diff: assert (func_sel != 2'd1 || result == opnd_b - opnd_a);
         a_r3_and_res: assert (func_sel != 2'd2 || result == (opnd_a & opnd_b));
         a_r4_xor_res: assert (func_sel != 2'd3 || result == (opnd_a ^ opnd_b));
         a_r5_zero_flag: assert (flag_zero == (result == '0));
         a_r6_add_carry: assert (func_sel != 2'd0 || flag_carry == ref_add[WIDTH]);
         a_r6_sub_borrow: assert (func_sel != 2'd1 || flag_carry == (opnd_b < opnd_a));
         a_r7_add_ovf: assert (func_sel != 2'd0 || flag_ovf ==
            ((opnd_a[MSB] == opnd_b[MSB]) && (result[MSB] != opnd_a[MSB])));
         a_r8_sub_ovf: assert (func_sel != 2'd1 || flag_ovf ==
            ((opnd_a[MSB] != opnd_b[MSB]) && (result[MSB] != opnd_b[MSB])));
         a_r9_logic_quiet: assert (!func_sel[1] || (!flag_carry && !flag_ovf));
      end
   end
endmodule

bind alu4_core alu4_core_chk #(.WIDTH(WIDTH)) u_chk (
   .opnd_a     (opnd_a),
   .opnd_b     (opnd_b),
   .func_sel   (func_sel),
   .result     (result),
   .flag_ovf   (flag_ovf),
   .flag_zero  (flag_zero),
   .flag_carry (flag_carry)
);

// File: tb/alu4_core_tb_top.sv
`timescale 1ns/1ps
module alu4_core_tb_top;
   localparam int unsigned W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] a_i = '0;
   logic [W-1:0] b_i = '0;
   logic [1:0]   fn_i = 2'd0;
   logic [W-1:0] res_o;
   logic         ovf_o, zero_o, carry_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   alu4_core #(.WIDTH(W)) dut_i (
      .opnd_a(a_i), .opnd_b(b_i), .func_sel(fn_i),
      .result(res_o), .flag_ovf(ovf_o), .flag_zero(zero_o), .flag_carry(carry_o)
   );

   task automatic chk(input string req, input logic [W+2:0] act, input logic [W+2:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h (fn=%0d a=%h b=%h)", req, act, exp, fn_i, a_i, b_i);
      end
   endtask

   // Applies one stimulus after a falling edge, samples 1 ns later, checks all outputs.
   task automatic apply_and_check(input logic [1:0] fn, input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W:0]   s;
      logic [W-1:0] r;
      logic         c, v;
      case (fn)
         2'd0: begin s = {1'b0, a} + {1'b0, b}; r = s[W-1:0]; c = s[W];
                     v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]); end
         2'd1: begin r = b - a; c = (b < a);
                     v = (a[W-1] != b[W-1]) && (r[W-1] != b[W-1]); end
         2'd2: begin r = a & b; c = 1'b0; v = 1'b0; end
         default: begin r = a ^ b; c = 1'b0; v = 1'b0; end
      endcase
      @(negedge clk);
      fn_i = fn; a_i = a; b_i = b;
      #1;
      chk(fn == 2'd0 ? "R1 add result" : fn == 2'd1 ? "R2 sub result" :
          fn == 2'd2 ? "R3 and result" : "R4 xor result", {3'b0, res_o}, {3'b0, r});
      chk("R5 zero flag", {{(W+2){1'b0}}, zero_o}, {{(W+2){1'b0}}, (r == '0)});
      chk(fn[1] ? "R9 carry cleared" : "R6 carry/borrow", {{(W+2){1'b0}}, carry_o}, {{(W+2){1'b0}}, c});
      chk(fn[1] ? "R9 ovf cleared" : (fn == 2'd0 ? "R7 add ovf" : "R8 sub ovf"),
          {{(W+2){1'b0}}, ovf_o}, {{(W+2){1'b0}}, v});
   endtask

   task automatic t_reset_state();
      // R5: all-zero inputs select add of zeros, result zero with flag set
      #1;
      chk("R5 reset-state result", {3'b0, res_o}, '0);
      chk("R5 reset-state zero", {{(W+2){1'b0}}, zero_o}, {{(W+2){1'b0}}, 1'b1});
   endtask

   task automatic t_add_corners();  // R1 R6 R7
      apply_and_check(2'd0, 32'hFFFF_FFFF, 32'h0000_0001);
      apply_and_check(2'd0, 32'h7FFF_FFFF, 32'h0000_0001);
      apply_and_check(2'd0, 32'h8000_0000, 32'h8000_0000);
      apply_and_check(2'd0, 32'h1234_5678, 32'h0000_0000);
   endtask

   task automatic t_sub_corners();  // R2 R6 R8
      apply_and_check(2'd1, 32'h0000_0001, 32'h0000_0000);
      apply_and_check(2'd1, 32'h0000_0001, 32'h8000_0000);
      apply_and_check(2'd1, 32'hFFFF_FFFF, 32'h7FFF_FFFF);
      apply_and_check(2'd1, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
      apply_and_check(2'd1, 32'h0000_0005, 32'h0000_0009);
   endtask

   task automatic t_logic_corners(); // R3 R4 R9
      apply_and_check(2'd2, 32'hF0F0_F0F0, 32'h0F0F_0F0F);
      apply_and_check(2'd2, 32'hFFFF_FFFF, 32'h8000_0001);
      apply_and_check(2'd3, 32'hA5A5_A5A5, 32'hA5A5_A5A5);
      apply_and_check(2'd3, 32'hFFFF_FFFF, 32'h0000_0001);
   endtask

   task automatic t_random();
      for (int i = 0; i < 400; i++) begin
         apply_and_check(2'(i % 4), $urandom(), $urandom());
      end
   endtask

   task automatic t_no_clock(); // R10
      @(negedge clk);
      fn_i = 2'd0; a_i = 32'd10; b_i = 32'd20;
      #1;
      chk("R10 first value", {3'b0, res_o}, {3'b0, 32'd30});
      fn_i = 2'd1;
      #1;
      chk("R10 follows func change", {3'b0, res_o}, {3'b0, 32'd10});
      a_i = 32'd25;
      #1;
      chk("R10 borrow follows operand", {{(W+2){1'b0}}, carry_o}, {{(W+2){1'b0}}, 1'b1});
   endtask

   initial begin
      t_reset_state();
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_add_corners();
      t_sub_corners();
      t_logic_corners();
      t_no_clock();
      t_random();
      done = 1'b1;
   end

   initial begin
      fork
         begin wait (done); end
         begin
            repeat (20000) @(posedge clk);
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule